// File: doc/BRIEF.md
# Receive Ring Writer

This block takes received Ethernet frames as a byte stream and stores them one after another in a single circular byte region of memory. Ahead of each frame it reserves one 32-bit header word. On the frame's first byte that word is written with a busy marker, so a host that walks the ring stops there. Once the last data word is in memory, the word is rewritten with the final byte count and a set of receive status flags. Headers always start on a 4-byte boundary. The next header follows the previous frame rounded up to a whole word, and data that runs past the top of the region continues at offset 0.

The host consumes frames and tells the block how far it has read through a read-pointer register. That register holds the consumer position minus 16, modulo the region size. The block uses it to work out how much space is free. It also drives an empty flag, which is set when the host's position equals the committed write pointer. A frame that cannot fit in the unread space is dropped: the rest of its bytes are swallowed, the write pointer stays where it was, and a saturating missed-frame counter goes up by one.

Top module: `rx_ring_writer`

## Requirements
- R1: After a synchronous active-low reset, `wr_ptr` is 0, `missed_cnt` is 0, `mem_we` is 0 and `in_ready` is 1. With `host_rd_ptr` equal to the region size minus 16, `buf_empty` is 1.
- R2: In the cycle a frame's first byte is accepted, the header word at `wr_ptr` is written as 0xFFF0_0000 (busy marker in the upper half, zero in the lower half).
- R3: Frame byte k is stored little-endian at byte offset `wr_ptr`+4+k, modulo the region size: word address offset>>2, lane offset&3. Unused lanes of the frame's last word are written as zero.
- R4: The final header is written after the last data word. Its upper 16 bits hold the number of bytes received, including the 4 CRC bytes. `in_ready` is 0 in the cycle after the last byte of a stored frame.
- R5: Header status bits are: bit0 OK, bit1 CRC error, bit2 alignment error, bit3 runt (length < MIN_LEN), bit4 giant (length > MAX_LEN), bit5 bad symbol, bits 15:6 zero. OK is 1 exactly when bits 5:1 are all 0. The error inputs are sampled with the last byte.
- R6: When a frame is stored, `wr_ptr` becomes (`wr_ptr` + 4 + length rounded up to a multiple of 4) modulo the region size, and it always stays word aligned.
- R7: Header and data writes that pass the end of the region continue from word 0.
- R8: The consumer position is (`host_rd_ptr` + 16) modulo the region size. `buf_empty` is 1 exactly when it equals `wr_ptr`.
- R9: Free space is the region size minus 4 minus the unread bytes. A frame needing more than that (4 + rounded length) is dropped: no write lands at or past the free space, `wr_ptr` is unchanged, `missed_cnt` goes up by one, and the next frame is stored normally.
- R10: `missed_cnt` saturates at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Byte on `in_data` is valid |
| in_data | input | 8 | Received frame byte |
| in_last | input | 1 | Marks the last byte of a frame |
| in_crc_err | input | 1 | CRC error, sampled with the last byte |
| in_align_err | input | 1 | Alignment error, sampled with the last byte |
| in_sym_err | input | 1 | Bad symbol seen, sampled with the last byte |
| in_ready | output | 1 | Byte is accepted when high together with `in_valid` |
| mem_we | output | 1 | Memory word write strobe |
| mem_addr | output | BUF_AW-2 | Word address in the ring |
| mem_wdata | output | 32 | Word written to memory |
| host_rd_ptr | input | BUF_AW | Host read register (consumer position minus 16) |
| wr_ptr | output | BUF_AW | Committed write position in bytes |
| buf_empty | output | 1 | Consumer position equals write position |
| missed_cnt | output | MISS_W | Saturating count of dropped frames |

## Verification
The bench builds the block with BUF_AW=8, which gives a 256-byte ring. With a ring that small, a handful of frames is enough to wrap the write position past the end and to fill the ring so that a 200-byte frame is refused. MAX_LEN=120 makes the giant flag reachable with a frame that still fits in the ring. MISS_W=2 lets four refused frames show the missed counter saturating at 3.

// File: rtl/rxr_pkg.sv
// Shared definitions for the receive ring writer.
// Assumes: header layout is fixed at 16-bit length over 16-bit status.
package rxr_pkg;
    typedef enum logic [2:0] {
        S_IDLE,   // waiting for a first byte
        S_FILL,   // copying frame bytes
        S_TAIL,   // writing the held word of a one-byte frame
        S_SEAL,   // writing the final header
        S_DROP    // discarding the rest of a refused frame
    } rxr_state_e;

    typedef struct packed {
        logic crc;
        logic align;
        logic sym;
    } rxr_err_t;

    localparam logic [15:0] BUSY_MARK = 16'hFFF0;
    localparam int ST_OK    = 0;
    localparam int ST_CRC   = 1;
    localparam int ST_ALIGN = 2;
    localparam int ST_RUNT  = 3;
    localparam int ST_GIANT = 4;
    localparam int ST_SYM   = 5;
endpackage

// File: rtl/rxr_space.sv
// Free-space and empty computation for the ring.
// Assumes: AW >= 5; the host register is the consumer position minus 16.
// The consumer position is rounded down to a word, which can only shrink free space.
module rxr_space #(
    parameter int AW = 13
) (
    input  logic [AW-1:0] wr_pos,
    input  logic [AW-1:0] host_rd,
    output logic [AW-1:0] rd_pos,
    output logic [AW:0]   free_bytes,
    output logic          empty
);
    localparam logic [AW:0]   CAP  = (AW+1)'(1) << AW;
    localparam logic [AW-1:0] BIAS = AW'(16);

    logic [AW-1:0] used;

    // Consumer position, unread bytes, free bytes and the empty flag.
    always_comb begin
        rd_pos     = (host_rd + BIAS) & ~AW'(3);
        used       = wr_pos - rd_pos;
        free_bytes = CAP - (AW+1)'(4) - {1'b0, used};
        empty      = (rd_pos == wr_pos);
    end
endmodule

// File: rtl/rxr_packer.sv
// Gathers frame bytes into little-endian 32-bit words.
// Assumes: 'start' is high with the first byte of each frame, so the count restarts there.
module rxr_packer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             start,
    input  logic [7:0]       data,
    output logic [31:0]      word_now,
    output logic [31:0]      word_held,
    output logic [CNT_W-1:0] cnt,
    output logic [1:0]       lane
);
    logic [31:0] acc_q;

    // Lane of the current byte and the word it completes.
    always_comb begin
        lane = start ? 2'd0 : cnt[1:0];
        word_now = (lane == 2'd0) ? 32'h0 : acc_q;
        word_now[8*lane +: 8] = data;
    end

    assign word_held = acc_q;

    // Hold the partial word and count accepted bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            cnt   <= '0;
        end else if (take) begin
            acc_q <= word_now;
            cnt   <= start ? CNT_W'(1) : cnt + CNT_W'(1);
        end
    end

    // Byte count moves by exactly one per accepted byte.
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !start) |=> (cnt == $past(cnt) + CNT_W'(1))); // R3
endmodule

// File: rtl/rxr_status.sv
// Builds the final header word from the byte count and the sampled error flags.
// Assumes: the length already includes the CRC bytes.
module rxr_status
    import rxr_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int MIN_LEN = 64,
    parameter int MAX_LEN = 1518
) (
    input  logic [CNT_W-1:0] len,
    input  rxr_err_t         err,
    output logic [31:0]      hdr
);
    logic runt, giant;

    // Length classes and the packed header.
    always_comb begin
        runt  = 32'(len) < 32'(MIN_LEN);
        giant = 32'(len) > 32'(MAX_LEN);
        hdr = '0;
        hdr[31:16]    = 16'(len);
        hdr[ST_CRC]   = err.crc;
        hdr[ST_ALIGN] = err.align;
        hdr[ST_RUNT]  = runt;
        hdr[ST_GIANT] = giant;
        hdr[ST_SYM]   = err.sym;
        hdr[ST_OK]    = !(err.crc || err.align || runt || giant || err.sym);
    end
endmodule

// File: rtl/rx_ring_writer.sv
// Receive ring writer: packs frames, each behind a header word, into a circular region.
// Assumes: the memory accepts one word write per cycle; the host only moves its read
// register forward over committed frames; BUF_AW >= 5.
module rx_ring_writer
    import rxr_pkg::*;
#(
    parameter int BUF_AW  = 13,
    parameter int CNT_W   = 16,
    parameter int MISS_W  = 16,
    parameter int MIN_LEN = 64,
    parameter int MAX_LEN = 1518
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    input  logic              in_crc_err,
    input  logic              in_align_err,
    input  logic              in_sym_err,
    output logic              in_ready,
    output logic              mem_we,
    output logic [BUF_AW-3:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [BUF_AW-1:0] host_rd_ptr,
    output logic [BUF_AW-1:0] wr_ptr,
    output logic              buf_empty,
    output logic [MISS_W-1:0] missed_cnt
);
    localparam int WA = BUF_AW - 2;
    localparam logic [WA-1:0] ONE_WORD = WA'(1);

    rxr_state_e        state_q, state_d;
    logic [BUF_AW-1:0] wr_q;
    logic [MISS_W-1:0] miss_q;
    rxr_err_t          err_q;

    logic              take, start, fits, miss_inc;
    logic [CNT_W-1:0]  cnt;
    logic [1:0]        lane;
    logic [31:0]       word_now, word_held, hdr_final;
    logic [BUF_AW-1:0] rd_pos;
    logic [BUF_AW:0]   free_b;
    logic [31:0]       cnt_after, rnd_now, rnd_fin, need, free32;
    logic [WA-1:0]     hdr_word;
    logic [BUF_AW-1:0] off_b;

    // Space left between the write and consumer positions.
    rxr_space #(.AW(BUF_AW)) u_space (
        .wr_pos(wr_q), .host_rd(host_rd_ptr),
        .rd_pos(rd_pos), .free_bytes(free_b), .empty(buf_empty)
    );

    // Byte-to-word gathering.
    rxr_packer #(.CNT_W(CNT_W)) u_packer (
        .clk(clk), .rst_n(rst_n), .take(take), .start(start), .data(in_data),
        .word_now(word_now), .word_held(word_held), .cnt(cnt), .lane(lane)
    );

    // Final header contents.
    rxr_status #(.CNT_W(CNT_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) u_status (
        .len(cnt), .err(err_q), .hdr(hdr_final)
    );

    assign start    = (state_q == S_IDLE);
    assign in_ready = (state_q == S_IDLE) || (state_q == S_FILL) || (state_q == S_DROP);
    assign take     = in_valid && in_ready;
    assign hdr_word = wr_q[BUF_AW-1:2];
    assign wr_ptr   = wr_q;
    assign missed_cnt = miss_q;

    // Room the frame needs if the current byte is kept, against what is free.
    always_comb begin
        cnt_after = start ? 32'd1 : 32'(cnt) + 32'd1;
        rnd_now   = (cnt_after + 32'd3) & ~32'd3;
        need      = rnd_now + 32'd4;
        free32    = 32'(free_b);
        fits      = (need <= free32);
        rnd_fin   = (32'(cnt) + 32'd3) & ~32'd3;
    end

    // Memory port and next state.
    always_comb begin
        mem_we    = 1'b0;
        mem_addr  = hdr_word;
        mem_wdata = 32'h0;
        miss_inc  = 1'b0;
        state_d   = state_q;
        case (state_q)
            S_IDLE: if (take) begin
                if (!fits) begin
                    miss_inc = in_last;
                    state_d  = in_last ? S_IDLE : S_DROP;
                end else begin
                    mem_we    = 1'b1;
                    mem_wdata = {BUSY_MARK, 16'h0};
                    state_d   = in_last ? S_TAIL : S_FILL;
                end
            end
            S_FILL: if (take) begin
                if (!fits) begin
                    miss_inc = in_last;
                    state_d  = in_last ? S_IDLE : S_DROP;
                end else begin
                    mem_we    = (lane == 2'd3) || in_last;
                    mem_addr  = hdr_word + ONE_WORD + WA'(cnt >> 2);
                    mem_wdata = word_now;
                    if (in_last) state_d = S_SEAL;
                end
            end
            S_TAIL: begin
                mem_we    = 1'b1;
                mem_addr  = hdr_word + ONE_WORD;
                mem_wdata = word_held;
                state_d   = S_SEAL;
            end
            S_SEAL: begin
                mem_we    = 1'b1;
                mem_wdata = hdr_final;
                state_d   = S_IDLE;
            end
            S_DROP: if (take && in_last) begin
                miss_inc = 1'b1;
                state_d  = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // State, write pointer, missed counter and sampled error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            wr_q    <= '0;
            miss_q  <= '0;
            err_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_SEAL)
                wr_q <= wr_q + BUF_AW'(rnd_fin) + BUF_AW'(4);
            if (miss_inc && (miss_q != '1))
                miss_q <= miss_q + MISS_W'(1);
            if (take && in_last)
                err_q <= '{crc: in_crc_err, align: in_align_err, sym: in_sym_err};
        end
    end

    // Offset of each write from the frame's header, for the space check.
    assign off_b = {mem_addr, 2'b00} - wr_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (32'(off_b) < free32)); // R9
    AST_WRPTR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_q[1:0] == 2'b00); // R6
    AST_PTR_ON_SEAL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wr_q) |-> ($past(mem_we) && ($past(mem_wdata[31:16]) != BUSY_MARK))); // R6
    AST_MARK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q == S_IDLE) && (state_q == S_FILL || state_q == S_TAIL))
        |-> ($past(mem_we) && ($past(mem_wdata) == {BUSY_MARK, 16'h0}))); // R2
    AST_SEAL_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SEAL) |-> ($past(mem_we) && !in_ready)); // R4
    AST_MISS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_q - $past(miss_q)) <= MISS_W'(1)); // R10
endmodule

// File: tb/rx_ring_writer_bench.sv
module rx_ring_writer_bench;
    localparam int AW    = 8;
    localparam int BUF_B = 1 << AW;
    localparam int NW    = BUF_B / 4;
    localparam int MINL  = 64;
    localparam int MAXL  = 120;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_last = 1'b0;
    logic [7:0] in_data = 8'h0;
    logic in_crc_err = 1'b0, in_align_err = 1'b0, in_sym_err = 1'b0;
    logic in_ready, mem_we, buf_empty;
    logic [AW-3:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [AW-1:0] host_rd_ptr = AW'(BUF_B - 16);
    logic [AW-1:0] wr_ptr;
    logic [1:0] missed_cnt;

    always #10 clk = ~clk;

    rx_ring_writer #(.BUF_AW(AW), .CNT_W(16), .MISS_W(2), .MIN_LEN(MINL), .MAX_LEN(MAXL))
    u_rx_ring_writer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .in_crc_err(in_crc_err), .in_align_err(in_align_err), .in_sym_err(in_sym_err),
        .in_ready(in_ready), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .host_rd_ptr(host_rd_ptr), .wr_ptr(wr_ptr), .buf_empty(buf_empty), .missed_cnt(missed_cnt)
    );

    int n_checks = 0, n_fail = 0;
    bit done = 1'b0;

    // Memory model with write tracking.
    logic [31:0] mem [NW];
    int cyc = 0, cur_frame = 0, seen_id = -1, hdr_idx = 0;
    int frame_base = 0, frame_free = BUF_B;
    int hdr_last_t = 0, data_last_t = 0, viol = 0;
    logic [31:0] hdr_first = 32'h0;

    initial for (int i = 0; i < NW; i++) mem[i] = 32'hA5A5A5A5;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
            if (((int'(mem_addr) * 4 - frame_base) & (BUF_B - 1)) >= frame_free) viol <= viol + 1;
            if (int'(mem_addr) == hdr_idx) begin
                if (seen_id != cur_frame) begin
                    hdr_first <= mem_wdata;
                    seen_id   <= cur_frame;
                end
                hdr_last_t <= cyc;
            end else begin
                data_last_t <= cyc;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] get_byte(input int off);
        logic [31:0] w;
        w = mem[(off & (BUF_B - 1)) >> 2];
        return w[8 * (off & 3) +: 8];
    endfunction

    function automatic logic [15:0] exp_status(input int len, input logic c, input logic a, input logic s);
        logic [15:0] st;
        st = 16'h0;
        st[1] = c; st[2] = a; st[3] = (len < MINL); st[4] = (len > MAXL); st[5] = s;
        st[0] = (st[5:1] == 5'b0);
        return st;
    endfunction

    int exp_wr = 0, exp_miss = 0;

    task automatic run_frame(input int len, input logic c, input logic a, input logic s,
                             input logic consume, input int seed);
        int rd, used, free, need, bad, rnd;
        bit drop;
        if (consume) begin
            @(negedge clk);
            host_rd_ptr = AW'(exp_wr - 16);
            @(negedge clk);
            chk("R8 empty after host catches up", 32'(buf_empty), 32'd1);
        end
        rd   = (int'(host_rd_ptr) + 16) & (BUF_B - 1) & ~3;
        used = (exp_wr - rd) & (BUF_B - 1);
        free = BUF_B - 4 - used;
        rnd  = (len + 3) & ~3;
        need = 4 + rnd;
        drop = need > free;
        cur_frame  = cur_frame + 1;
        hdr_idx    = exp_wr >> 2;
        frame_base = exp_wr;
        frame_free = free;
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            while (!in_ready) @(negedge clk);
            in_valid = 1'b1;
            in_data  = 8'(seed + k * 7);
            in_last  = (k == len - 1);
            in_crc_err   = (k == len - 1) ? c : 1'b0;
            in_align_err = (k == len - 1) ? a : 1'b0;
            in_sym_err   = (k == len - 1) ? s : 1'b0;
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        in_crc_err = 1'b0; in_align_err = 1'b0; in_sym_err = 1'b0;
        if (!drop) chk("R4 ready low while header finalises", 32'(in_ready), 32'd0);
        repeat (4) @(negedge clk);
        if (drop) begin
            exp_miss = (exp_miss < 3) ? exp_miss + 1 : 3;
            chk("R9 write pointer kept on drop", 32'(wr_ptr), 32'(exp_wr));
            chk("R9/R10 missed count", 32'(missed_cnt), 32'(exp_miss));
        end else begin
            chk("R2 busy marker first", hdr_first, 32'hFFF00000);
            chk("R4/R5 final header", mem[hdr_idx], {16'(len), exp_status(len, c, a, s)});
            chk("R4 header after data", 32'(data_last_t < hdr_last_t), 32'd1);
            bad = 0;
            for (int k = 0; k < rnd; k++) begin
                if (get_byte(exp_wr + 4 + k) !== ((k < len) ? 8'(seed + k * 7) : 8'h00)) bad++;
            end
            if (exp_wr + need > BUF_B) chk("R7 wrapped frame bytes", 32'(bad), 32'd0);
            else chk("R3 frame bytes and padding", 32'(bad), 32'd0);
            exp_wr = (exp_wr + need) & (BUF_B - 1);
            chk("R6 write pointer advance", 32'(wr_ptr), 32'(exp_wr));
        end
        chk("R8 empty flag", 32'(buf_empty), 32'(rd == exp_wr));
    endtask

    // {consume, sym, align, crc, len}
    localparam logic [19:0] VEC [9] = '{
        {1'b0, 3'b000, 16'd64},
        {1'b0, 3'b001, 16'd70},
        {1'b0, 3'b010, 16'd61},
        {1'b1, 3'b100, 16'd65},
        {1'b0, 3'b000, 16'd200},
        {1'b1, 3'b000, 16'd100},
        {1'b1, 3'b000, 16'd1},
        {1'b1, 3'b000, 16'd121},
        {1'b1, 3'b111, 16'd3}
    };

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 mem_we in reset", 32'(mem_we), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 wr_ptr", 32'(wr_ptr), 32'd0);
        chk("R1 missed", 32'(missed_cnt), 32'd0);
        chk("R1 ready", 32'(in_ready), 32'd1);
        chk("R1 empty", 32'(buf_empty), 32'd1);
        chk("R1 no write", 32'(mem_we), 32'd0);
        for (int v = 0; v < 9; v++) begin
            run_frame(int'(VEC[v][15:0]), VEC[v][16], VEC[v][17], VEC[v][18], VEC[v][19], v * 31 + 5);
        end
        // Directed: refused frames drive the counter to saturation (R10).
        for (int d = 0; d < 4; d++) run_frame(250, 1'b0, 1'b0, 1'b0, 1'b0, 9 + d);
        chk("R10 saturated count", 32'(missed_cnt), 32'd3);
        // Directed: normal frame after drops still stored (R9).
        run_frame(68, 1'b0, 1'b0, 1'b0, 1'b1, 77);
        chk("R9 no write past free space", 32'(viol), 32'd0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule